// File: doc/BRIEF.md
# Rotating Byte Checksum Engine

This block folds a stream of bytes into an 8-bit checksum. It is used to check a span of stored data. A controller pulses a start input together with a byte count. The block then takes bytes over a valid/ready handshake, one per clock at most. When the counted number of bytes has been absorbed, it raises a one-cycle done strobe and presents the final checksum.

The checksum is not an additive sum. For each byte, the running value is rotated left by one bit, with bit 7 moving to bit 0. It is then XORed with the byte, and the byte also carries a fixed salt of 0x53 (the `SALT` parameter). Fetching the bytes from storage and delivering the result elsewhere are left to the surrounding logic.

Top module: `rotsum_engine`

## Requirements
- R1: While reset is asserted, and right after it is released, `done_o`, `byte_ready_o` and `busy_o` are 0 and `sum_o` is 0x00.
- R2: Each absorbed byte `b` replaces the running sum `s` with `{s[6:0], s[7]} ^ b ^ 0x53`, visible on `sum_o` the cycle after the handshake. From a sum of 0x00, one byte 0x00 gives 0x53 and two bytes 0x00 give 0xF5.
- R3: A byte is absorbed on a clock edge only when `byte_valid_i` and `byte_ready_o` are both 1. `byte_ready_o` is 1 from the cycle after an accepted start until exactly `len_i` bytes have been absorbed, and 0 otherwise.
- R4: `done_o` is a one-cycle pulse. It comes in the cycle after the last byte is absorbed, and `sum_o` then holds the final checksum. `sum_o` keeps that value until the next accepted start.
- R5: A start with `len_i` = 0 raises `done_o` in the next cycle, with `sum_o` = 0x00, and absorbs no byte.
- R6: A start pulse while `busy_o` is 1 has no effect on the byte count, the sum or the timing of done.
- R7: While a job is running, a cycle with `byte_valid_i` low leaves `sum_o` and the remaining count unchanged.
- R8: An accepted start clears the sum, so `sum_o` reads 0x00 in the next cycle.
- R9: A start is accepted whenever `busy_o` is 0, including the cycle in which `done_o` is high. This allows back-to-back jobs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted when not busy |
| len_i | input | LEN_W | Number of bytes to fold, sampled with an accepted start |
| byte_valid_i | input | 1 | Input byte is valid |
| byte_i | input | 8 | Input byte |
| byte_ready_o | output | 1 | Engine will absorb a byte at the next edge |
| busy_o | output | 1 | A job is running and bytes are still owed |
| done_o | output | 1 | One-cycle strobe: the checksum is final |
| sum_o | output | 8 | Running / final checksum |

## Verification
A wrong rotate direction, a missing salt or a dropped wrap bit makes `sum_o` differ from the reference the cycle after the first absorbed byte. The sum is compared on every clock, so the fault shows at once and is not hidden until done. A miscounted length shows up in `byte_ready_o` and `done_o` one cycle early or late, on the edge where the count should have reached its end. A start pulse that is wrongly honoured mid-job clears `sum_o` in the next cycle, and that clearing is caught by the same per-cycle comparison.

// File: rtl/rotsum_pkg.sv
package rotsum_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_FIN  = 2'd2
  } rs_state_e;

  localparam int unsigned RS_BYTE_W = 8;
  localparam logic [RS_BYTE_W-1:0] RS_DEFAULT_SALT = 8'h53;
endpackage

// File: rtl/rotsum_ctrl.sv
module rotsum_ctrl
  import rotsum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic take_i,
  input  logic last_i,
  output logic accept_o,
  output logic run_o,
  output logic fin_o
);
  rs_state_e state_q, state_d;

  // a start is honoured only when no bytes are owed
  assign accept_o = start_i && (state_q != RS_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE: if (accept_o) state_d = len_zero_i ? RS_FIN : RS_RUN;
      RS_RUN:  if (take_i && last_i) state_d = RS_FIN;
      RS_FIN: begin
        if (accept_o) state_d = len_zero_i ? RS_FIN : RS_RUN;
        else          state_d = RS_IDLE;
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_IDLE;
    else        state_q <= state_d;
  end

  assign run_o = (state_q == RS_RUN);
  assign fin_o = (state_q == RS_FIN);
endmodule

// File: rtl/rotsum_len_cnt.sv
module rotsum_len_cnt #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             len_zero_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = len_i;
    else if (dec_i) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o     = (cnt_q == ONE);
  assign len_zero_o = (len_i == '0);
endmodule

// File: rtl/rotsum_acc.sv
module rotsum_acc #(
  parameter int unsigned          W    = 8,
  parameter logic [W-1:0]         SALT = 8'h53
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         take_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] sum_q, sum_d, rot;
  logic         sum_en;

  // left rotate by one: bit i takes bit i-1, bit 0 takes the top bit
  for (genvar i = 0; i < W; i++) begin : g_rot
    if (i == 0) begin : g_wrap
      assign rot[i] = sum_q[W-1];
    end else begin : g_shift
      assign rot[i] = sum_q[i-1];
    end
  end

  assign sum_en = clr_i || take_i;

  always_comb begin
    sum_d = sum_q;
    if (clr_i)       sum_d = '0;
    else if (take_i) sum_d = rot ^ din_i ^ SALT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/rotsum_engine.sv
module rotsum_engine
  import rotsum_pkg::*;
#(
  parameter int unsigned          LEN_W = 16,
  parameter logic [RS_BYTE_W-1:0] SALT  = RS_DEFAULT_SALT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 byte_valid_i,
  input  logic [RS_BYTE_W-1:0] byte_i,
  output logic                 byte_ready_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [RS_BYTE_W-1:0] sum_o
);
  logic accept, run, fin, take, last, len_zero;

  assign take = byte_valid_i && run;

  rotsum_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_zero_i (len_zero),
    .take_i     (take),
    .last_i     (last),
    .accept_o   (accept),
    .run_o      (run),
    .fin_o      (fin)
  );

  rotsum_len_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .len_i      (len_i),
    .dec_i      (take),
    .last_o     (last),
    .len_zero_o (len_zero)
  );

  rotsum_acc #(.W(RS_BYTE_W), .SALT(SALT)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .take_i (take),
    .din_i  (byte_i),
    .sum_o  (sum_o)
  );

  assign byte_ready_o = run;
  assign busy_o       = run;
  assign done_o       = fin;
endmodule

// File: rtl/rotsum_engine_chk.sv
module rotsum_engine_chk #(
  parameter int unsigned LEN_W = 16,
  parameter logic [7:0]  SALT  = 8'h53
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             byte_valid_i,
  input logic [7:0]       byte_i,
  input logic             byte_ready_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [7:0]       sum_o
);
  // R2
  fold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && byte_ready_o) |=>
      sum_o == ({$past(sum_o[6:0]), $past(sum_o[7])} ^ $past(byte_i) ^ SALT));

  // R3
  no_ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !byte_ready_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);

  // R4
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(sum_o));

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && len_i == '0) |=> (done_o && sum_o == 8'h00));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !byte_valid_i) |=> ($stable(sum_o) && busy_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready_o && !byte_valid_i) |=> $stable(sum_o));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> sum_o == 8'h00);
endmodule

bind rotsum_engine rotsum_engine_chk #(.LEN_W(LEN_W), .SALT(SALT)) u_chk (.*);

// File: tb/tb_rotsum_engine.sv
module tb_rotsum_engine;
  localparam int LEN_W = 16;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [LEN_W-1:0] len_i;
  logic             byte_valid_i;
  logic [7:0]       byte_i;
  logic             byte_ready_o;
  logic             busy_o;
  logic             done_o;
  logic [7:0]       sum_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  rotsum_engine #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(byte_ready_o),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference: job phase 0 idle, 1 owing bytes, 2 finished
  int m_phase;
  int m_left;
  int m_sum;

  function automatic int fold(int s, int b);
    int r;
    r = ((s << 1) & 8'hFE) | ((s >> 7) & 1);
    return (r ^ b ^ 8'h53) & 8'hFF;
  endfunction

  function automatic int fold_list(int q[$]);
    int s = 0;
    foreach (q[k]) s = fold(s, q[k]);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_sum = 0;
    end else if (m_phase != 1 && start_i) begin
      m_sum = 0; m_left = int'(len_i);
      m_phase = (m_left == 0) ? 2 : 1;
    end else if (m_phase == 1) begin
      if (byte_valid_i) begin
        m_sum = fold(m_sum, int'(byte_i));
        m_left = m_left - 1;
        if (m_left == 0) m_phase = 2;
      end
    end else if (m_phase == 2) begin
      m_phase = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 done", int'(done_o), int'(m_phase == 2));
      check("R3 ready", int'(byte_ready_o), int'(m_phase == 1));
      check("R6 busy", int'(busy_o), int'(m_phase == 1));
      check("R2 sum", int'(sum_o), m_sum);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic pulse_start(int len);
    @(negedge clk);
    start_i = 1'b1; len_i = LEN_W'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // feed bytes; gap>0 inserts an idle cycle every gap bytes
  task automatic feed(int q[$], int gap);
    int idx = 0;
    int cnt = 0;
    bit acc;
    while (idx < q.size()) begin
      if (gap > 0 && cnt % (gap + 1) == gap) begin
        byte_valid_i = 1'b0;
        byte_i = 8'hA5;
      end else begin
        byte_valid_i = 1'b1;
        byte_i = 8'(q[idx]);
      end
      acc = byte_valid_i && byte_ready_o;
      @(posedge clk);
      if (acc) idx++;
      cnt++;
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
  endtask

  task automatic wait_done(output int s);
    int guard = 0;
    while (!done_o && guard < 1000) begin
      @(negedge clk); guard++;
    end
    s = int'(sum_o);
  endtask

  initial begin
    int q[$];
    int s;
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; byte_valid_i = 1'b0; byte_i = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done_o), 0);
    check("R1 ready", int'(byte_ready_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 sum", int'(sum_o), 0);
    rst_n = 1'b1;

    // R2 single zero byte gives 0x53
    pulse_start(1);
    check("R8 sum cleared", int'(sum_o), 0);
    q = '{0};
    feed(q, 0);
    wait_done(s);
    check("R2 one byte", s, 8'h53);
    @(negedge clk);
    check("R4 held", int'(sum_o), 8'h53);
    check("R4 pulse", int'(done_o), 0);

    // R2 two zero bytes give 0xF5
    pulse_start(2);
    q = '{0, 0};
    feed(q, 0);
    wait_done(s);
    check("R2 two bytes", s, 8'hF5);

    // R5 zero length
    @(negedge clk);
    start_i = 1'b1; len_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    check("R5 done", int'(done_o), 1);
    check("R5 sum", int'(sum_o), 0);
    check("R5 ready", int'(byte_ready_o), 0);

    // R7 stalls inside a longer job
    q = {};
    for (int k = 0; k < 20; k++) q.push_back((k * 37 + 11) & 8'hFF);
    pulse_start(20);
    feed(q, 2);
    wait_done(s);
    check("R7 stalled job", s, fold_list(q));

    // R3 ready stays low after done, offered bytes change nothing
    @(negedge clk);
    byte_valid_i = 1'b1; byte_i = 8'h3C;
    repeat (3) @(negedge clk);
    check("R3 idle ready", int'(byte_ready_o), 0);
    check("R3 sum untouched", int'(sum_o), fold_list(q));
    byte_valid_i = 1'b0;

    // R6 start while busy, with another length
    q = '{8'h80, 8'h01, 8'hFF, 8'h53};
    pulse_start(4);
    byte_valid_i = 1'b1; byte_i = 8'(q[0]);
    @(negedge clk);
    byte_valid_i = 1'b0;
    start_i = 1'b1; len_i = LEN_W'(1);
    @(negedge clk);
    start_i = 1'b0;
    check("R6 still busy", int'(busy_o), 1);
    q.delete(0);
    feed(q, 0);
    wait_done(s);
    check("R6 sum", s, fold_list('{8'h80, 8'h01, 8'hFF, 8'h53}));

    // R9 start accepted in the done cycle
    pulse_start(3);
    q = '{8'h12, 8'h34, 8'h56};
    feed(q, 0);
    wait_done(s);
    check("R9 first", s, fold_list(q));
    start_i = 1'b1; len_i = LEN_W'(2);
    @(negedge clk);
    start_i = 1'b0;
    check("R9 accepted", int'(busy_o), 1);
    check("R8 cleared", int'(sum_o), 0);
    q = '{8'hFE, 8'h01};
    feed(q, 1);
    wait_done(s);
    check("R9 second", s, fold_list(q));

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule